// File: doc/BRIEF.md
# Watchdog Timer with Timed Reset Hold

This block watches firmware liveness. A small counter advances once per slow tick, which comes from a free-running timer with a nominal period of 1.024 ms. Firmware keeps the counter from expiring by writing to a restart address. The data of that write does not matter, and the location cannot be read back. If firmware stops writing, the counter's top bit eventually goes from 0 to 1. The block then drives a chip reset and holds it for a fixed number of further ticks. In the same cycle it raises a one-cycle pulse that sets the watchdog status flag. It also locks the USB transmitter off.

The transmitter lock stays in place after the reset ends. It is released only when firmware clears the watchdog status flag, which reaches the block as a clear request. While the device is suspended the tick does not advance the counter. Firmware that restarts the watchdog just after a tick therefore gets nearly eight full tick periods. Firmware that restarts just before a tick gets one period less.

Top module: `wdog_hold`

## Requirements
- R1: After `rst_n` is released, `wd_reset`, `wd_flag_set` and `tx_disable` are 0, and the counter starts from zero.
- R2: A cycle with `wr_en`=1 and `wr_addr`=0x21 clears the counter to zero. A write to any other address leaves the count unchanged.
- R3: With the default 4-bit counter, the 8th counted tick since the last clear moves the counter top bit from 0 to 1. `wd_reset` rises in the cycle after that tick is sampled. Seven ticks never assert it.
- R4: `wd_reset` stays 1 for exactly 8 ticks and falls in the cycle after the 8th of them is sampled. These ticks count whether or not `suspend` is high. During the hold the counter stays at zero and restart writes have no effect, so after the hold a fresh run of 8 ticks is needed.
- R5: `wd_flag_set` is a one-cycle pulse in the first cycle of `wd_reset`.
- R6: `tx_disable` rises together with `wd_reset`. It stays 1, through the hold and after it, until a cycle with `flag_clr`=1 and `wd_reset`=0 is sampled. It is 0 in the cycle after that one. A clear request during the hold is ignored.
- R7: A tick sampled while `suspend`=1 does not advance the counter, outside the hold.
- R8: A restart write in the same cycle as a tick wins: the counter ends at zero and no reset is triggered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low power-on reset |
| tick | input | 1 | Slow timer tick, a one-cycle pulse (or a level, when the level option is chosen) |
| wr_en | input | 1 | Bus write strobe |
| wr_addr | input | ADDR_W | Bus write address |
| flag_clr | input | 1 | Firmware request to clear the watchdog flag |
| suspend | input | 1 | Device suspended; stops counting |
| wd_reset | output | 1 | Chip reset driven by the watchdog |
| wd_flag_set | output | 1 | One-cycle pulse that sets the watchdog status flag |
| tx_disable | output | 1 | USB transmitter lock-off |

## Verification
Every output is a register loaded on the same edge that samples the stimulus. Each result therefore appears exactly one cycle after the input cycle that causes it: the 8th counted tick, the 8th hold tick, or an accepted clear. The bench drives one input cycle per step on the falling edge and compares all three outputs at the next falling edge. It uses a tick-by-tick arithmetic model built from the requirements. The sweeps move the restart write across every tick phase, try off-target addresses, alternate suspend, and make a restart write coincide with the expiring tick.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

   typedef enum logic {
      WD_ARMED   = 1'b0,
      WD_HOLDING = 1'b1
   } wd_mode_e;

   // Width of a counter that must represent values 0 .. n-1.
   function automatic int unsigned idx_bits(input int unsigned n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction

endpackage

// File: rtl/wdog_tick.sv
module wdog_tick #(
   parameter bit TICK_IS_LEVEL = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick,
   output logic tick_evt
);
   generate
      if (TICK_IS_LEVEL) begin : g_edge
         logic tick_prev;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) tick_prev <= 1'b0;
            else        tick_prev <= tick;
         end
         assign tick_evt = tick & ~tick_prev;
      end else begin : g_pulse
         logic unused_rst;
         assign unused_rst = rst_n & clk;
         assign tick_evt   = tick;
      end
   endgenerate
endmodule

// File: rtl/wdog_count.sv
module wdog_count #(
   parameter int unsigned          CNT_W        = 4,
   parameter int unsigned          ADDR_W       = 8,
   parameter logic [ADDR_W-1:0]    RESTART_ADDR = 8'h21
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick_evt,
   input  logic              suspend,
   input  logic              holding,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   output logic              trip
);
   // The top bit rises when the count leaves 0111..1.
   localparam logic [CNT_W-1:0] LAST_LOW = {1'b0, {(CNT_W-1){1'b1}}};

   logic [CNT_W-1:0] cnt;
   logic             restart;
   logic             advance;

   assign restart = wr_en && (wr_addr == RESTART_ADDR);
   assign advance = tick_evt && !suspend && !holding && !restart;
   assign trip    = advance && (cnt == LAST_LOW);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                   cnt <= '0;
      else if (holding || restart)  cnt <= '0;
      else if (trip)                cnt <= '0;
      else if (advance)             cnt <= cnt + 1'b1;
   end
endmodule

// File: rtl/wdog_hold_ctl.sv
module wdog_hold_ctl
   import wdog_pkg::*;
#(
   parameter int unsigned HOLD_TICKS = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic trip,
   input  logic tick_evt,
   output logic holding,
   output logic flag_pulse
);
   localparam int unsigned      HW    = idx_bits(HOLD_TICKS);
   localparam logic [HW-1:0]    HLAST = HW'(HOLD_TICKS - 1);

   wd_mode_e       mode;
   logic [HW-1:0]  hcnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode       <= WD_ARMED;
         hcnt       <= '0;
         flag_pulse <= 1'b0;
      end else begin
         flag_pulse <= 1'b0;
         case (mode)
            WD_ARMED: begin
               if (trip) begin
                  mode       <= WD_HOLDING;
                  hcnt       <= '0;
                  flag_pulse <= 1'b1;
               end
            end
            WD_HOLDING: begin
               if (tick_evt) begin
                  if (hcnt == HLAST) begin
                     mode <= WD_ARMED;
                     hcnt <= '0;
                  end else begin
                     hcnt <= hcnt + 1'b1;
                  end
               end
            end
            default: mode <= WD_ARMED;
         endcase
      end
   end

   assign holding = (mode == WD_HOLDING);
endmodule

// File: rtl/wdog_hold.sv
module wdog_hold #(
   parameter int unsigned       CNT_W         = 4,
   parameter int unsigned       HOLD_TICKS    = 8,
   parameter int unsigned       ADDR_W        = 8,
   parameter logic [ADDR_W-1:0] RESTART_ADDR  = 8'h21,
   parameter bit                TICK_IS_LEVEL = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic              flag_clr,
   input  logic              suspend,
   output logic              wd_reset,
   output logic              wd_flag_set,
   output logic              tx_disable
);
   generate
      if (CNT_W < 2) begin : g_bad_cnt
         $error("wdog_hold: CNT_W must be at least 2");
      end
      if (HOLD_TICKS < 1) begin : g_bad_hold
         $error("wdog_hold: HOLD_TICKS must be at least 1");
      end
      if (ADDR_W < 1) begin : g_bad_addr
         $error("wdog_hold: ADDR_W must be at least 1");
      end
   endgenerate

   logic tick_evt;
   logic trip;
   logic holding;
   logic tx_lock;

   wdog_tick #(.TICK_IS_LEVEL(TICK_IS_LEVEL)) u_tick (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick     (tick),
      .tick_evt (tick_evt)
   );

   wdog_count #(
      .CNT_W        (CNT_W),
      .ADDR_W       (ADDR_W),
      .RESTART_ADDR (RESTART_ADDR)
   ) u_count (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick_evt (tick_evt),
      .suspend  (suspend),
      .holding  (holding),
      .wr_en    (wr_en),
      .wr_addr  (wr_addr),
      .trip     (trip)
   );

   wdog_hold_ctl #(.HOLD_TICKS(HOLD_TICKS)) u_hold (
      .clk        (clk),
      .rst_n      (rst_n),
      .trip       (trip),
      .tick_evt   (tick_evt),
      .holding    (holding),
      .flag_pulse (wd_flag_set)
   );

   // Transmitter lock: set on expiry, released only by a clear outside the hold.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                     tx_lock <= 1'b0;
      else if (trip)                  tx_lock <= 1'b1;
      else if (flag_clr && !holding)  tx_lock <= 1'b0;
   end

   assign wd_reset   = holding;
   assign tx_disable = tx_lock;
endmodule

// File: rtl/wdog_hold_chk.sv
module wdog_hold_chk #(
   parameter int unsigned       HOLD_TICKS    = 8,
   parameter int unsigned       ADDR_W        = 8,
   parameter logic [ADDR_W-1:0] RESTART_ADDR  = 8'h21,
   parameter bit                TICK_IS_LEVEL = 1'b0
) (
   input logic              clk,
   input logic              rst_n,
   input logic              tick,
   input logic              wr_en,
   input logic [ADDR_W-1:0] wr_addr,
   input logic              flag_clr,
   input logic              suspend,
   input logic              wd_reset,
   input logic              wd_flag_set,
   input logic              tx_disable
);
   localparam int unsigned CW = $clog2(HOLD_TICKS + 1);

   logic          tick_prev;
   logic          tick_seen;
   logic [CW-1:0] held_ticks;

   assign tick_seen = TICK_IS_LEVEL ? (tick && !tick_prev) : tick;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tick_prev  <= 1'b0;
         held_ticks <= '0;
      end else begin
         tick_prev <= tick;
         if (!wd_reset)      held_ticks <= '0;
         else if (tick_seen) held_ticks <= held_ticks + 1'b1;
      end
   end

   // R4: the reset never outlasts its tick budget
   p_hold_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
      wd_reset |-> (held_ticks < CW'(HOLD_TICKS)));

   // R5: flag pulse lasts one cycle and accompanies the rise of reset
   p_flag_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
      wd_flag_set |=> !wd_flag_set);
   p_flag_on_rise_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(wd_reset) |-> wd_flag_set);

   // R6: transmitter locked at reset, and only an accepted clear releases it
   p_tx_on_rise_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(wd_reset) |-> tx_disable);
   p_tx_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_disable && !(flag_clr && !wd_reset)) |=> tx_disable);

   // R2: a restart write outside the hold prevents a reset on the next cycle
   p_restart_blocks_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!wd_reset && wr_en && (wr_addr == RESTART_ADDR)) |=> !wd_reset);

   // R7: a suspended cycle cannot be the one that trips the watchdog
   p_suspend_no_trip_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(wd_reset) |-> $past(!suspend));
endmodule

bind wdog_hold wdog_hold_chk #(
   .HOLD_TICKS    (HOLD_TICKS),
   .ADDR_W        (ADDR_W),
   .RESTART_ADDR  (RESTART_ADDR),
   .TICK_IS_LEVEL (TICK_IS_LEVEL)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .tick        (tick),
   .wr_en       (wr_en),
   .wr_addr     (wr_addr),
   .flag_clr    (flag_clr),
   .suspend     (suspend),
   .wd_reset    (wd_reset),
   .wd_flag_set (wd_flag_set),
   .tx_disable  (tx_disable)
);

// File: tb/wdog_hold_test.sv
module wdog_hold_test;
   localparam int CLK_PERIOD = 10;
   localparam int EXPIRE     = 8;     // 4-bit counter: top bit rises on tick 8
   localparam int HOLD       = 8;
   localparam logic [7:0] RST_ADDR = 8'h21;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tick = 1'b0;
   logic       wr_en = 1'b0;
   logic [7:0] wr_addr = 8'h00;
   logic       flag_clr = 1'b0;
   logic       suspend = 1'b0;
   logic       wd_reset, wd_flag_set, tx_disable;

   int vectors = 0;
   int errors  = 0;

   // Arithmetic model state, built from the requirements
   int   m_cnt  = 0;
   int   m_hcnt = 0;
   logic m_hold = 1'b0;
   logic m_flag = 1'b0;
   logic m_tx   = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   wdog_hold uut (
      .clk         (clk),
      .rst_n       (rst_n),
      .tick        (tick),
      .wr_en       (wr_en),
      .wr_addr     (wr_addr),
      .flag_clr    (flag_clr),
      .suspend     (suspend),
      .wd_reset    (wd_reset),
      .wd_flag_set (wd_flag_set),
      .tx_disable  (tx_disable)
   );

   task automatic compare(input string req);
      vectors++;
      if ({wd_reset, wd_flag_set, tx_disable} !== {m_hold, m_flag, m_tx}) begin
         errors++;
         $display("FAIL %s: {reset,flag,txdis} actual=%b%b%b expected=%b%b%b at %0t",
                  req, wd_reset, wd_flag_set, tx_disable, m_hold, m_flag, m_tx, $time);
      end
   endtask

   // One input cycle, driven at a falling edge; outputs compared at the next.
   task automatic step(input logic t, input logic w, input logic [7:0] a,
                       input logic s, input logic c, input string req);
      logic fire;
      tick = t; wr_en = w; wr_addr = a; suspend = s; flag_clr = c;
      @(negedge clk);
      tick = 1'b0; wr_en = 1'b0; flag_clr = 1'b0;
      fire = 1'b0;
      if (m_hold) begin
         if (t) begin
            m_hcnt++;
            if (m_hcnt == HOLD) begin m_hold = 1'b0; m_hcnt = 0; end
         end
      end else begin
         if (w && a == RST_ADDR) m_cnt = 0;
         else if (t && !s) begin
            m_cnt++;
            if (m_cnt == EXPIRE) begin
               fire = 1'b1; m_hold = 1'b1; m_hcnt = 0; m_cnt = 0;
            end
         end
         if (c) m_tx = 1'b0;
      end
      if (fire) m_tx = 1'b1;
      m_flag = fire;
      compare(req);
   endtask

   task automatic ticks(input int n, input string req);
      for (int i = 0; i < n; i++) step(1'b1, 1'b0, 8'h00, 1'b0, 1'b0, req);
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      errors++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      compare("R1");                              // R1 reset state
      step(1'b0, 1'b0, 8'h00, 1'b0, 1'b0, "R1");

      // R3 expiry after 8 ticks, R5 pulse, R6 lock
      ticks(9, "R3");
      step(1'b0, 1'b0, 8'h00, 1'b0, 1'b1, "R6");  // clear during hold ignored
      step(1'b0, 1'b1, RST_ADDR, 1'b0, 1'b0, "R4"); // restart during hold ignored
      step(1'b1, 1'b0, 8'h00, 1'b1, 1'b0, "R4");  // hold tick counts while suspended
      ticks(9, "R4");
      step(1'b0, 1'b0, 8'h00, 1'b0, 1'b1, "R6");  // accepted clear
      step(1'b0, 1'b0, 8'h00, 1'b0, 1'b0, "R5");

      // R2 sweep of restart phase
      for (int k = 0; k < EXPIRE; k++) begin
         ticks(k, "R2");
         step(1'b0, 1'b1, RST_ADDR, 1'b0, 1'b0, "R2");
         ticks(EXPIRE + 2, "R2");
         ticks(HOLD, "R4");
         step(1'b0, 1'b0, 8'h00, 1'b0, 1'b1, "R6");
      end

      // R2 off-target addresses do not restart
      for (int j = 0; j < 4; j++) begin
         logic [7:0] bad;
         bad = (j == 0) ? 8'h20 : (j == 1) ? 8'h22 : (j == 2) ? 8'h01 : 8'hA1;
         ticks(3, "R2");
         step(1'b0, 1'b1, bad, 1'b0, 1'b0, "R2");
         ticks(6, "R2");
         ticks(HOLD, "R4");
         step(1'b0, 1'b0, 8'h00, 1'b0, 1'b1, "R6");
      end

      // R7 suspend alternating with live ticks
      step(1'b0, 1'b1, RST_ADDR, 1'b0, 1'b0, "R7");
      for (int i = 0; i < 20; i++)
         step(1'b1, 1'b0, 8'h00, i[0], 1'b0, "R7");
      ticks(HOLD, "R7");
      step(1'b0, 1'b0, 8'h00, 1'b0, 1'b1, "R6");

      // R8 restart coinciding with the expiring tick
      step(1'b0, 1'b1, RST_ADDR, 1'b0, 1'b0, "R8");
      ticks(EXPIRE - 1, "R8");
      step(1'b1, 1'b1, RST_ADDR, 1'b0, 1'b0, "R8");
      ticks(EXPIRE, "R8");
      ticks(HOLD, "R8");
      step(1'b0, 1'b0, 8'h00, 1'b0, 1'b1, "R6");

      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
   end
endmodule